// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two strobes of a multiplexed external bus on a small 8-bit controller: an address latch enable (active high) and a program store enable (active low). It follows a machine cycle of twelve oscillator periods. The cycle is split into two halves of six periods, and each half holds one address-latch slot and one program-fetch slot. A phase counter kept elsewhere supplies the current oscillator period within the machine cycle.

The surrounding core tells the block three things: whether code is fetched from external memory, whether the current machine cycle carries an external data transfer, and whether software has set the configuration bit that quiets the address latch strobe while the bus is idle. Two power-state requests override everything else. Idle parks both strobes high. Power-down parks both strobes low, and it wins over idle when both are requested.

Both outputs are registered. Each output value reflects the inputs sampled at the previous rising clock edge.

Top module: `ext_bus_strobe`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `ale`=0 and `psen_n`=1, whatever the other inputs are.
- R2: In run mode, with the quiet bit clear and no data transfer, `ale` is 1 for `cyc_phase` values 0, 1, 6 and 7 and is 0 for every other phase from 0 to 11.
- R3: In run mode, in a machine cycle where `data_xfer`=1, the second-half pulse (phases 6 and 7) is dropped and the first-half pulse (phases 0 and 1) is kept.
- R4: In run mode, with `fetch_ext`=1 and `data_xfer`=0, `psen_n` is 0 for phases 3, 4, 5, 9, 10 and 11 and is 1 for all other phases.
- R5: In run mode, with `data_xfer`=1, `psen_n` stays 1 for all twelve phases, so both fetch activations of that cycle are dropped.
- R6: In run mode, with `fetch_ext`=0 (internal fetch), `psen_n` stays 1 for all phases.
- R7: With `ale_quiet`=1 in run mode, `ale` stays 0 when both `fetch_ext` and `data_xfer` are 0. When either of them is 1, `ale` follows R2 and R3 as if `ale_quiet` were 0.
- R8: With `idle_req`=1 and `pdown_req`=0, both `ale` and `psen_n` are 1, whatever the phase and the other controls are.
- R9: With `pdown_req`=1, both `ale` and `psen_n` are 0, whatever `idle_req` and the other inputs are.
- R10: Each output changes exactly one clock after the inputs that determine it are sampled. The outputs never depend combinationally on the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_phase | input | 4 | Oscillator period within the machine cycle, 0 to 11 |
| fetch_ext | input | 1 | 1 when program code is fetched from external memory |
| data_xfer | input | 1 | 1 during a machine cycle with an external data transfer |
| ale_quiet | input | 1 | Configuration bit: silence the latch strobe while the bus is idle |
| idle_req | input | 1 | Idle power state |
| pdown_req | input | 1 | Power-down state, overrides idle |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable, active low |

## Verification
A wrong phase decode moves or stretches a strobe window. That error shows at the ports within one machine cycle, twelve clocks at most. A wrong skip or quiet decision leaves a pulse that should be missing, or drops one that should be present, in the first machine cycle that carries a data transfer or an idle bus. A wrong power-state priority shows on the first clock after the request. The bench sweeps every combination of controls and power states across every phase of two machine cycles, so every such error is seen within a few clocks of the combination that triggers it.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_IDLE  = 2'd1,
    PWR_PDOWN = 2'd2
  } pwr_mode_e;

  // Power-down outranks idle when both are requested.
  function automatic pwr_mode_e pick_mode(input logic idle_req, input logic pdown_req);
    if (pdown_req)     return PWR_PDOWN;
    else if (idle_req) return PWR_IDLE;
    else               return PWR_RUN;
  endfunction

endpackage

// File: rtl/strobe_phase_dec.sv
module strobe_phase_dec #(
  parameter int CYC_LEN  = 12,
  parameter int ALE_LEN  = 2,
  parameter int PSEN_OFF = 3,
  parameter int PSEN_LEN = 3,
  parameter int PHASE_W  = $clog2(CYC_LEN)
) (
  input  logic [PHASE_W-1:0] phase,
  output logic               slot,
  output logic               ale_win,
  output logic               psen_win
);
  localparam int HALF = CYC_LEN / 2;
  localparam logic [PHASE_W-1:0] HALF_C  = PHASE_W'(HALF);
  localparam logic [PHASE_W-1:0] ALE_END = PHASE_W'(ALE_LEN);
  localparam logic [PHASE_W-1:0] PS_BEG  = PHASE_W'(PSEN_OFF);
  localparam logic [PHASE_W-1:0] PS_END  = PHASE_W'(PSEN_OFF + PSEN_LEN);

  logic [PHASE_W-1:0] ofs;

  always_comb begin
    slot     = (phase >= HALF_C);
    ofs      = slot ? (phase - HALF_C) : phase;
    ale_win  = (ofs < ALE_END);
    psen_win = (ofs >= PS_BEG) && (ofs < PS_END);
  end
endmodule

// File: rtl/strobe_ale_gen.sv
module strobe_ale_gen
  import strobe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ale_win,
  input  logic      slot,
  input  logic      fetch_ext,
  input  logic      data_xfer,
  input  logic      ale_quiet,
  input  pwr_mode_e mode,
  output logic      ale
);
  logic bus_busy, allowed, skip, ale_d;

  always_comb begin
    bus_busy = fetch_ext | data_xfer;
    allowed  = ~ale_quiet | bus_busy;
    skip     = data_xfer & slot;
    unique case (mode)
      PWR_PDOWN: ale_d = 1'b0;
      PWR_IDLE:  ale_d = 1'b1;
      default:   ale_d = ale_win & allowed & ~skip;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ale <= 1'b0;
    else     ale <= ale_d;
  end

  assert_skip_second_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == PWR_RUN && data_xfer && slot) |=> !ale);
  assert_quiet_low_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == PWR_RUN && ale_quiet && !fetch_ext && !data_xfer) |=> !ale);
  assert_no_pulse_outside_window_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == PWR_RUN && !ale_win) |=> !ale);
endmodule

// File: rtl/strobe_psen_gen.sv
module strobe_psen_gen
  import strobe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      psen_win,
  input  logic      fetch_ext,
  input  logic      data_xfer,
  input  pwr_mode_e mode,
  output logic      psen_n
);
  logic psen_n_d;

  always_comb begin
    unique case (mode)
      PWR_PDOWN: psen_n_d = 1'b0;
      PWR_IDLE:  psen_n_d = 1'b1;
      default:   psen_n_d = ~(psen_win & fetch_ext & ~data_xfer);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) psen_n <= 1'b1;
    else     psen_n <= psen_n_d;
  end

  assert_internal_fetch_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == PWR_RUN && !fetch_ext) |=> psen_n);
  assert_data_drops_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == PWR_RUN && data_xfer) |=> psen_n);
endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe
  import strobe_pkg::*;
#(
  parameter int CYC_LEN  = 12,
  parameter int ALE_LEN  = 2,
  parameter int PSEN_OFF = 3,
  parameter int PSEN_LEN = 3,
  parameter int PHASE_W  = $clog2(CYC_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] cyc_phase,
  input  logic               fetch_ext,
  input  logic               data_xfer,
  input  logic               ale_quiet,
  input  logic               idle_req,
  input  logic               pdown_req,
  output logic               ale,
  output logic               psen_n
);
  logic      slot, ale_win, psen_win;
  pwr_mode_e mode;

  assign mode = pick_mode(idle_req, pdown_req);

  strobe_phase_dec #(
    .CYC_LEN(CYC_LEN), .ALE_LEN(ALE_LEN), .PSEN_OFF(PSEN_OFF),
    .PSEN_LEN(PSEN_LEN), .PHASE_W(PHASE_W)
  ) u_dec (
    .phase(cyc_phase), .slot(slot), .ale_win(ale_win), .psen_win(psen_win)
  );

  strobe_ale_gen u_ale (
    .clk(clk), .rst(rst), .ale_win(ale_win), .slot(slot),
    .fetch_ext(fetch_ext), .data_xfer(data_xfer), .ale_quiet(ale_quiet),
    .mode(mode), .ale(ale)
  );

  strobe_psen_gen u_psen (
    .clk(clk), .rst(rst), .psen_win(psen_win), .fetch_ext(fetch_ext),
    .data_xfer(data_xfer), .mode(mode), .psen_n(psen_n)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!ale && psen_n));
  assert_idle_parks_high_R8: assert property (@(posedge clk) disable iff (rst)
    (idle_req && !pdown_req) |=> (ale && psen_n));
  assert_pdown_parks_low_R9: assert property (@(posedge clk) disable iff (rst)
    pdown_req |=> (!ale && !psen_n));
endmodule

// File: tb/test_ext_bus_strobe.sv
module test_ext_bus_strobe;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cyc_phase = '0;
  logic       fetch_ext = 1'b0, data_xfer = 1'b0, ale_quiet = 1'b0;
  logic       idle_req = 1'b0, pdown_req = 1'b0;
  logic       ale, psen_n;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ext_bus_strobe i_ext_bus_strobe (
    .clk(clk), .rst(rst), .cyc_phase(cyc_phase), .fetch_ext(fetch_ext),
    .data_xfer(data_xfer), .ale_quiet(ale_quiet), .idle_req(idle_req),
    .pdown_req(pdown_req), .ale(ale), .psen_n(psen_n)
  );

  function automatic logic exp_ale(int p, logic f, logic d, logic q, logic idl, logic pd);
    if (pd)  return 1'b0;                 // R9
    if (idl) return 1'b1;                 // R8
    if (q && !f && !d) return 1'b0;       // R7
    if ((p % 6) >= 2) return 1'b0;        // R2
    if (d && (p / 6) == 1) return 1'b0;   // R3
    return 1'b1;
  endfunction

  function automatic logic exp_psen_n(int p, logic f, logic d, logic idl, logic pd);
    if (pd)  return 1'b0;                 // R9
    if (idl) return 1'b1;                 // R8
    if (!f || d) return 1'b1;             // R5, R6
    return !((p % 6) >= 3);               // R4
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string tag(logic f, logic d, logic q, logic idl, logic pd);
    if (pd)  return "R9";
    if (idl) return "R8";
    if (q)   return "R7";
    if (d)   return "R3/R5";
    if (!f)  return "R2/R6";
    return "R2/R4";
  endfunction

  initial begin
    // R1: reset dominates an idle request
    idle_req = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1", ale, 1'b0, "ale in reset");
    check("R1", psen_n, 1'b1, "psen_n in reset");
    @(negedge clk);
    rst = 1'b0; idle_req = 1'b0;

    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < 24; k++) begin
          logic f, d, q, idl, pd;
          int p;
          p = k % 12;
          f = c[0]; d = c[1]; q = c[2];
          idl = m[0]; pd = m[1];
          @(negedge clk);
          cyc_phase = 4'(p); fetch_ext = f; data_xfer = d; ale_quiet = q;
          idle_req = idl; pdown_req = pd;
          @(posedge clk);
          #2;  // R10: result of the inputs sampled at this edge
          check(tag(f, d, q, idl, pd), ale, exp_ale(p, f, d, q, idl, pd), "ale");
          check(tag(f, d, q, idl, pd), psen_n, exp_psen_n(p, f, d, idl, pd), "psen_n");
        end
      end
    end

    // R10: outputs hold until the next edge after an input change
    @(negedge clk);
    idle_req = 1'b0; pdown_req = 1'b0; fetch_ext = 1'b1; data_xfer = 1'b0;
    ale_quiet = 1'b0; cyc_phase = 4'd0;
    @(posedge clk); #2;
    check("R10", ale, 1'b1, "ale at phase 0");
    @(negedge clk);
    cyc_phase = 4'd3;
    #1;
    check("R10", ale, 1'b1, "ale before edge");
    check("R10", psen_n, 1'b1, "psen_n before edge");
    @(posedge clk); #2;
    check("R10", ale, 1'b0, "ale after edge");
    check("R10", psen_n, 1'b0, "psen_n after edge");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule